// File: doc/BRIEF.md
# Step-Adaptive Moving Average Filter

This block sits behind a first-stage decimation filter in a data-converter datapath. It runs in parallel with a second-stage FIR filter that lives outside the block. Each first-stage sample arrives together with the matching FIR result. The block compares the new sample with the sample accepted two positions earlier. When the two differ by more than 1% of positive full scale, or when a channel switch has been signalled, it stops forwarding the FIR result. In its place it emits a moving average of the most recent first-stage samples. The length of that average then grows in fixed stages until the block hands the output back to the FIR path. A settling flag is high for the whole episode, so a consumer can tell a fast estimate from a fully filtered result.

Both inputs are valid/ready streams that are joined: a sample pair is taken only when the first-stage sample and the FIR result are both valid and the single output register is free. Neither input is ever consumed alone. An input's ready therefore depends on the other input's valid. The result stream follows the usual back-pressure rule. Once `res_valid` is high, `res_data` stays unchanged until the cycle in which `res_ready` is also high. The output register is free whenever it is empty or is being drained in the same cycle. The control and status pins have no handshake.

In single-shot operation a result leaves the block only on request, except during a settling episode. In that case results keep coming until the flag falls. Pairs that are not emitted are still consumed, so the filter state keeps tracking the input.

Top module: `step_adapt_avg`

## Requirements
- R1: While `adapt_en` is 0, every emitted result equals the FIR value of the same pair, `settling` is 0 with it, and the block never enters averaging.
- R2: A step is the magnitude of (new sample minus the sample accepted two pairs earlier) strictly greater than 83886, which is (2^23-1)/100 rounded, for DW=24. A difference of exactly 83886 is not a step. The sample that carries the step is averaged over 2 samples when `chop_on` is 1 and over 1 sample when it is 0.
- R3: A channel switch forces averaging on the next accepted pair, whatever the values are. The history is refilled with that pair's sample, so its result equals the sample itself. The very first pair after reset also refills the history, but it does not start an episode.
- R4: While successive samples keep exceeding the step threshold, the result keeps the initial length of 2 or 1.
- R5: After the first sample that does not exceed the threshold, the results use, in order: 2 results averaged over 2, then 4 over 4, then 8 over 8, then 6 over 16. The next pair's FIR value is then emitted.
- R6: An average over L (L = 1, 2, 4, 8 or 16) is the sum of the current sample and the L-1 samples before it, arithmetically shifted right by log2(L). The result therefore rounds toward minus infinity.
- R7: `settling` goes to 1 with the first averaged result of an episode and is 1 with every averaged result. It is 0 with every FIR result, so it falls together with the first FIR result after the schedule.
- R8: A step or channel switch in the middle of the schedule restarts it at the initial length, and `settling` stays 1.
- R9: A pair is accepted only when both input streams are valid and the output register is free. `res_data` holds while `res_valid` is 1 and `res_ready` is 0.
- R10: With `single_shot` 1, an accepted pair produces a result only if a `conv_req` pulse came in that cycle or since the last emitted result, or if `settling` was 1 before the pair. Otherwise the pair is consumed silently.
- R11: A `chan_switch` pulse that arrives in a cycle with no accepted pair is held, and it applies to the next accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | First-stage sample valid |
| smp_ready | output | 1 | First-stage sample accepted (joined with FIR stream) |
| smp_data | input | DW | First-stage sample, signed two's complement |
| fir_valid | input | 1 | FIR result valid |
| fir_ready | output | 1 | FIR result accepted (joined with sample stream) |
| fir_data | input | DW | FIR result, signed two's complement |
| chan_switch | input | 1 | Pulse: input channel has changed |
| chop_on | input | 1 | Chop mode; selects initial average length 2 (1) or 1 (0) |
| adapt_en | input | 1 | Enables step-adaptive averaging |
| single_shot | input | 1 | Emit results only on request or while settling |
| conv_req | input | 1 | Pulse: request one result in single-shot operation |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_data | output | DW | Selected result, signed |
| settling | output | 1 | High while results come from the moving average |

## Verification
A channel switch can arrive in the same cycle as a pair acceptance. In that case three things must happen on that very pair: the history refill, the forced episode start and the suppression of step detection. The same pulse arriving between pairs must be held and applied one pair later. The bench drives the switch both ways, coinciding with the accepted pair and alone in an idle cycle, and tags the results R3 and R11. The same coincidence is provoked for `conv_req` in single-shot operation, where a request arriving with a pair must emit that pair. Every result is compared, value and flag, against an arithmetic model in the bench while random back-pressure is applied to the result stream.

// File: rtl/step_adapt_pkg.sv
package step_adapt_pkg;

  typedef enum logic [2:0] {
    PH_FIR  = 3'd0,
    PH_INIT = 3'd1,
    PH_L2   = 3'd2,
    PH_L4   = 3'd3,
    PH_L8   = 3'd4,
    PH_L16  = 3'd5
  } phase_e;

  // log2 of the averaging length used in each scheduled phase
  function automatic logic [2:0] phase_lg(input phase_e p);
    case (p)
      PH_L2:   return 3'd1;
      PH_L4:   return 3'd2;
      PH_L8:   return 3'd3;
      PH_L16:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sam_history.sv
module sam_history #(
  parameter int DW    = 24,
  parameter int DEPTH = 16,
  localparam int LG   = $clog2(DEPTH),
  localparam int SW   = DW + LG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 preload,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] two_back,
  output logic signed [SW-1:0] sums_o [LG+1]
);

  logic signed [DW-1:0] hist [DEPTH-1];
  logic signed [DW-1:0] win  [DEPTH];
  logic signed [SW-1:0] pre  [DEPTH+1];

  // window: current sample first, then older samples; a refill sees only din
  assign win[0] = din;
  for (genvar i = 1; i < DEPTH; i++) begin : g_win
    assign win[i] = preload ? din : hist[i-1];
  end

  assign pre[0] = '0;
  for (genvar i = 0; i < DEPTH; i++) begin : g_pre
    assign pre[i+1] = pre[i] + SW'(win[i]);
  end

  for (genvar k = 0; k <= LG; k++) begin : g_sum
    assign sums_o[k] = pre[1 << k];
  end

  assign two_back = hist[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH-1; i++) hist[i] <= '0;
    end else if (shift_en) begin
      if (preload) begin
        for (int i = 0; i < DEPTH-1; i++) hist[i] <= din;
      end else begin
        hist[0] <= din;
        for (int i = 1; i < DEPTH-1; i++) hist[i] <= hist[i-1];
      end
    end
  end

  AST_PRELOAD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && preload |=> hist[0] == $past(din) && hist[DEPTH-2] == $past(din))
    else $error("history refill incomplete"); // R3

endmodule

// File: rtl/sam_step_detect.sv
module sam_step_detect #(
  parameter int DW  = 24,
  parameter int THR = 83886
) (
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] ref_smp,
  output logic                 hit
);

  logic signed [DW:0] diff;
  logic        [DW:0] mag;

  assign diff = {cur[DW-1], cur} - {ref_smp[DW-1], ref_smp};
  assign mag  = diff[DW] ? (DW+1)'(-diff) : (DW+1)'(diff);
  assign hit  = mag > (DW+1)'(THR);

endmodule

// File: rtl/sam_schedule.sv
module sam_schedule
  import step_adapt_pkg::*;
#(
  parameter int RUN_L2  = 2,
  parameter int RUN_L4  = 4,
  parameter int RUN_L8  = 8,
  parameter int RUN_L16 = 6,
  localparam int CW     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       en,
  input  logic       trig,
  input  logic       chop,
  output logic       use_avg,
  output logic [2:0] len_lg,
  output logic       settle_q
);

  phase_e          ph_q, ph_n, cur, nxt;
  logic [CW-1:0]   cnt_q, cnt_n, lim;

  always_comb begin
    ph_n    = ph_q;
    cnt_n   = cnt_q;
    use_avg = 1'b0;
    len_lg  = 3'd0;
    cur     = (ph_q == PH_INIT) ? PH_L2 : ph_q;
    case (cur)
      PH_L2:   begin lim = CW'(RUN_L2);  nxt = PH_L4;  end
      PH_L4:   begin lim = CW'(RUN_L4);  nxt = PH_L8;  end
      PH_L8:   begin lim = CW'(RUN_L8);  nxt = PH_L16; end
      PH_L16:  begin lim = CW'(RUN_L16); nxt = PH_FIR; end
      default: begin lim = CW'(1);       nxt = PH_FIR; end
    endcase
    if (!en) begin
      ph_n  = PH_FIR;
      cnt_n = '0;
    end else if (trig) begin
      ph_n    = PH_INIT;
      cnt_n   = '0;
      use_avg = 1'b1;
      len_lg  = chop ? 3'd1 : 3'd0;
    end else if (ph_q != PH_FIR) begin
      use_avg = 1'b1;
      len_lg  = phase_lg(cur);
      if (cnt_q == lim - CW'(1)) begin
        cnt_n = '0;
        ph_n  = nxt;
      end else begin
        cnt_n = cnt_q + CW'(1);
        ph_n  = cur;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_FIR;
      cnt_q    <= '0;
      settle_q <= 1'b0;
    end else if (advance) begin
      ph_q     <= ph_n;
      cnt_q    <= cnt_n;
      settle_q <= use_avg;
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_L16 |-> cnt_q < CW'(RUN_L16))
    else $error("final run too long"); // R5
  AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    advance && en && trig |=> ph_q == PH_INIT && settle_q)
    else $error("trigger did not restart schedule"); // R8
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !en |=> ph_q == PH_FIR && !settle_q)
    else $error("averaging while disabled"); // R1
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    advance && en && !trig && ph_q == PH_L16 && cnt_q == CW'(RUN_L16 - 1)
    |=> ph_q == PH_FIR && settle_q)
    else $error("schedule exit wrong"); // R7

endmodule

// File: rtl/step_adapt_avg.sv
module step_adapt_avg
  import step_adapt_pkg::*;
#(
  parameter int DW      = 24,
  parameter int DEPTH   = 16,
  parameter int THR_DIV = 100,
  localparam int LG     = $clog2(DEPTH),
  localparam int SW     = DW + LG,
  localparam int THR    = ((2**(DW-1)) - 1 + THR_DIV/2) / THR_DIV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_data,
  input  logic          fir_valid,
  output logic          fir_ready,
  input  logic [DW-1:0] fir_data,
  input  logic          chan_switch,
  input  logic          chop_on,
  input  logic          adapt_en,
  input  logic          single_shot,
  input  logic          conv_req,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data
  ,output logic         settling
);

  logic slot_free, fire, chan_pend, chan_now, primed, preload;
  logic step_hit, trig, use_avg, armed_q, emit;
  logic [2:0]           len_lg;
  logic signed [DW-1:0] two_back;
  logic signed [SW-1:0] sums [LG+1];
  logic signed [DW-1:0] avg_k [LG+1];
  logic signed [DW-1:0] avg_val;
  logic        [DW-1:0] result;

  // joined input streams, single output register
  assign slot_free = !res_valid || res_ready;
  assign smp_ready = slot_free && fir_valid;
  assign fir_ready = slot_free && smp_valid;
  assign fire      = slot_free && smp_valid && fir_valid;

  assign chan_now = chan_pend || chan_switch;
  assign preload  = chan_now || !primed;
  assign trig     = chan_now || (!preload && step_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_pend <= 1'b0;
      primed    <= 1'b0;
    end else if (fire) begin
      chan_pend <= 1'b0;
      primed    <= 1'b1;
    end else if (chan_switch) begin
      chan_pend <= 1'b1;
    end
  end

  sam_history #(.DW(DW), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (fire),
    .preload  (preload),
    .din      ($signed(smp_data)),
    .two_back (two_back),
    .sums_o   (sums)
  );

  sam_step_detect #(.DW(DW), .THR(THR)) u_step (
    .cur     ($signed(smp_data)),
    .ref_smp (two_back),
    .hit     (step_hit)
  );

  sam_schedule u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (fire),
    .en       (adapt_en),
    .trig     (trig),
    .chop     (chop_on),
    .use_avg  (use_avg),
    .len_lg   (len_lg),
    .settle_q (settling)
  );

  for (genvar k = 0; k <= LG; k++) begin : g_avg
    assign avg_k[k] = DW'(sums[k] >>> k);
  end
  assign avg_val = avg_k[len_lg];
  assign result  = use_avg ? avg_val : fir_data;

  // single-shot gating
  assign emit = !single_shot || armed_q || conv_req || settling;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      if (fire) armed_q <= emit ? 1'b0 : armed_q;
      else      armed_q <= armed_q || conv_req;
      if (fire) begin
        res_valid <= emit;
        if (emit) res_data <= result;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data))
    else $error("result changed under back-pressure"); // R9
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !adapt_en && !single_shot |=> res_valid && res_data == $past(fir_data) && !settling)
    else $error("disabled path not FIR"); // R1
  AST_SINGLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && single_shot && !armed_q && !conv_req && !settling |=> !res_valid)
    else $error("unrequested single-shot result"); // R10
  AST_CHAN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    fire && adapt_en && chan_now && !single_shot |=> res_data == $past(smp_data) && settling)
    else $error("channel switch result wrong"); // R3

endmodule

// File: tb/step_adapt_avg_tb.sv
module step_adapt_avg_tb;
  localparam int    DW  = 24;
  localparam longint THR = 83886;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, smp_valid, smp_ready, fir_valid, fir_ready, chan_switch;
  logic chop_on, adapt_en, single_shot, conv_req, res_valid, res_ready, settling;
  logic [DW-1:0] smp_data, fir_data, res_data;

  step_adapt_avg u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .fir_valid(fir_valid), .fir_ready(fir_ready),
    .fir_data(fir_data), .chan_switch(chan_switch), .chop_on(chop_on),
    .adapt_en(adapt_en), .single_shot(single_shot), .conv_req(conv_req),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .settling(settling)
  );

  int checks = 0, errs = 0;
  longint mh [15];
  bit mprimed = 0, mchan = 0, marmed = 0, mset = 0, bp_on = 0;
  int mph = 0, mdone = 0;
  longint q_d [$];
  bit     q_s [$];
  string  q_t [$];

  function automatic longint fval(longint x);
    return x / 2 + 12345;
  endfunction

  function automatic int runlen(int ph);
    case (ph)
      2: return 2;
      3: return 4;
      4: return 8;
      default: return 6;
    endcase
  endfunction

  task automatic model_fire(longint x, longint f, bit cpulse, bit creq);
    bit c, clr, stp, trig, av, emit;
    longint d, res, sum;
    longint win [16];
    int lg;
    string tg;
    c = mchan || cpulse;
    clr = c || !mprimed;
    d = x - mh[1];
    if (d < 0) d = -d;
    stp = mprimed && !clr && (d > THR);
    trig = c || stp;
    av = 0; lg = 0; res = f;
    win[0] = x;
    for (int i = 1; i < 16; i++) win[i] = clr ? x : mh[i-1];
    if (!adapt_en) begin
      mph = 0; mdone = 0; tg = "R1";
    end else if (trig) begin
      tg = mchan ? "R11" : c ? "R3" : (mph == 1) ? "R4" : (mph != 0) ? "R8" : "R2";
      mph = 1; mdone = 0; av = 1; lg = chop_on ? 1 : 0;
    end else if (mph != 0) begin
      if (mph == 1) begin mph = 2; mdone = 0; end
      lg = mph - 1; av = 1;
      tg = (lg == 4) ? "R6" : "R5";
      mdone++;
      if (mdone == runlen(mph)) begin
        mdone = 0;
        mph = (mph == 5) ? 0 : mph + 1;
      end
    end else begin
      tg = (mprimed && !clr && d == THR) ? "R2" : "R5";
    end
    if (av) begin
      sum = 0;
      for (int i = 0; i < (1 << lg); i++) sum += win[i];
      res = sum >>> lg;
    end
    emit = !single_shot || marmed || creq || mset;
    if (emit) marmed = 0;
    if (single_shot) tg = "R10";
    mset = av;
    if (emit) begin q_d.push_back(res); q_s.push_back(av); q_t.push_back(tg); end
    if (clr) for (int i = 0; i < 15; i++) mh[i] = x;
    else begin
      for (int i = 14; i > 0; i--) mh[i] = mh[i-1];
      mh[0] = x;
    end
    mprimed = 1; mchan = 0;
  endtask

  task automatic push(longint x, bit cp, bit cr, bit lag);
    bit done, first;
    done = 0; first = 1;
    @(negedge clk);
    if (lag) begin
      smp_valid = 1; fir_valid = 0; smp_data = DW'(x);
      #1;
      checks++;
      if (smp_ready !== 1'b0) begin
        errs++; $display("FAIL R9 lone sample accepted: ready=%0b expected 0", smp_ready);
      end
      @(negedge clk);
    end
    while (!done) begin
      smp_valid = 1; fir_valid = 1; smp_data = DW'(x); fir_data = DW'(fval(x));
      chan_switch = first ? cp : 1'b0;
      conv_req = first ? cr : 1'b0;
      #1;
      if (smp_ready && fir_ready) begin
        model_fire(x, fval(x), chan_switch, conv_req);
        done = 1;
      end else begin
        if (chan_switch) mchan = 1;
        if (conv_req) marmed = 1;
      end
      first = 0;
      @(negedge clk);
    end
    smp_valid = 0; fir_valid = 0; chan_switch = 0; conv_req = 0;
  endtask

  task automatic hold(longint x, int n);
    for (int i = 0; i < n; i++) push(x, 0, 0, 0);
  endtask

  task automatic pulse_chan();
    @(negedge clk);
    chan_switch = 1;
    mchan = 1;
    @(negedge clk);
    chan_switch = 0;
  endtask

  task automatic run_block(longint b);
    push(b, 1, 0, 0);                      // R3 switch with pair
    hold(b, 3);
    push(b + THR, 0, 0, 0);                // R2 equal to threshold: no step
    push(b + THR + 1, 0, 0, 0);            // R2 step vs two back
    hold(b + THR + 1, 24);                 // R5 R6 full schedule
    hold(b, 1);
    hold(b, 6);
    push(b - 250000, 0, 0, 0);             // R8 retrigger
    hold(b - 250000, 26);
    for (int i = 1; i <= 4; i++) push(b - 250000 + i * 100000, 0, 0, 0); // R4
    hold(b + 150000, 26);
    push(b + 150000, 0, 0, 1);             // R9 lagging FIR stream
    pulse_chan();                          // R11
    push(b - 40000, 0, 0, 0);
    hold(b - 40000, 24);
  endtask

  // result consumer with optional random back-pressure
  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    res_ready = 1;
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      res_ready = bp_on ? (lf[0] | lf[1]) : 1'b1;
    end
  end

  // monitor
  initial begin
    bit pv, pr;
    logic [DW-1:0] pd;
    pv = 0; pr = 1; pd = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (pv && !pr) begin
          checks++;
          if (!(res_valid && res_data == pd)) begin
            errs++; $display("FAIL R9 hold: valid=%0b data=%0d expected %0d", res_valid, $signed(res_data), $signed(pd));
          end
        end
        if (res_valid && res_ready) begin
          checks += 2;
          if (q_d.size() == 0) begin
            errs++; $display("FAIL R10 unexpected result %0d expected none", $signed(res_data));
          end else begin
            if (longint'($signed(res_data)) != q_d[0]) begin
              errs++; $display("FAIL %s data=%0d expected %0d", q_t[0], $signed(res_data), q_d[0]);
            end
            if (settling != q_s[0]) begin
              errs++; $display("FAIL R7 (%s) settling=%0b expected %0b", q_t[0], settling, q_s[0]);
            end
            void'(q_d.pop_front()); void'(q_s.pop_front()); void'(q_t.pop_front());
          end
        end
      end
      pv = res_valid; pr = res_ready; pd = res_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) mh[i] = 0;
    rst_n = 0; smp_valid = 0; fir_valid = 0; smp_data = '0; fir_data = '0;
    chan_switch = 0; chop_on = 0; adapt_en = 0; single_shot = 0; conv_req = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks += 2;
    if (res_valid !== 1'b0) begin errs++; $display("FAIL R9 reset res_valid=%0b expected 0", res_valid); end
    if (settling !== 1'b0) begin errs++; $display("FAIL R7 reset settling=%0b expected 0", settling); end
    rst_n = 1;
    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 2; c++) begin
        adapt_en = e[0]; chop_on = c[0]; bp_on = (c == 1);
        run_block((e * 2 + c) % 2 == 0 ? 1000000 : -2000000);
      end
    end
    adapt_en = 1; chop_on = 1; bp_on = 0; single_shot = 1;   // R10
    hold(300000, 5);
    push(300000, 0, 1, 0);
    hold(300000, 3);
    @(negedge clk); conv_req = 1; marmed = 1; @(negedge clk); conv_req = 0;
    push(300000, 0, 0, 0);
    push(-500000, 0, 0, 0);
    hold(-500000, 26);
    single_shot = 0;
    bp_on = 0;
    repeat (20) @(negedge clk);
    checks++;
    if (q_d.size() != 0) begin
      errs++; $display("FAIL R9 missing results: %0d pending expected 0", q_d.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule